// File: doc/BRIEF.md
# Impedance calibration search sequencer

This block finds the pull-up and pull-down drive codes for output impedance calibration. It runs a series of trials. Each trial presents a trial code pair and its saturated plus-one neighbours to an analog comparator. It powers the comparator for a fixed settle window and reads one result bit at the end of that window. The comparator is then switched off until the next trial begins.

A run has two phases. The first is a linear sweep of the 5-bit pull-up code against the external reference resistor. The second is a linear sweep of the 4-bit pull-down code against the pull-up code the first phase found. In low-power DRAM mode a third phase follows. The found pull-down code is raised by a fixed offset, and the pull-up code is searched again against that raised pull-down.

A run is launched by a start pulse or by an optional periodic timer. The result is reported with a one-cycle done pulse and held on the result outputs. Loading the codes into the drivers happens outside this block.

Top module: `zq_search_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `cmp_en_o` are 0, and both result codes are 0.
- R2: The first phase compares with `cmp_sel_o`=0 and trial pull-down code 0. It steps the pull-up code upward from 0 and keeps the first code at which the comparator returns 1. If code 31 also returns 0, the phase result is 0.
- R3: The second phase compares with `cmp_sel_o`=1, holding the pull-up at the first-phase result. It steps the pull-down code from 0 to 14. The result is one less than the first code above 0 that returns 0. If no such code is seen, the result is 0.
- R4: `trial_pu_p1_o` is the trial pull-up code plus one, saturating at 31. `trial_pd_p1_o` is the trial pull-down code plus one, saturating at 15.
- R5: Each trial holds `cmp_en_o` high for exactly SETTLE_CYC cycles and samples the comparator on the last of them. `cmp_en_o` is low for at least one cycle between trials.
- R6: When `lp_mode_i` is 1 at start, the second-phase result plus PD_OFFSET, saturated at 15, becomes the final pull-down code. The pull-up code is then searched again from 0 with `cmp_sel_o`=1 against that code, keeping the first code that returns 1, or 0 if none does. When `lp_mode_i` is 0, the run ends after the second phase.
- R7: `done_o` is high for exactly one cycle at the end of a run. The result codes change only in that cycle and hold until the next run completes.
- R8: A start request while `busy_o` is high has no effect on the run in progress, and does not cause another run.
- R9: With `recal_en_i`=1 and a nonzero `recal_interval_i` of N, `busy_o` rises N cycles after the first idle cycle. With an interval of 0, no run is launched.
- R10: `busy_o` is high from the cycle after a start is accepted until `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a calibration run (taken only when idle) |
| lp_mode_i | input | 1 | Low-power DRAM mode, sampled at start |
| recal_en_i | input | 1 | Enable periodic automatic runs |
| recal_interval_i | input | IVL_W | Idle cycles before an automatic run, 0 disables |
| cmp_result_i | input | 1 | Comparator result bit |
| cmp_en_o | output | 1 | Comparator power enable |
| cmp_sel_o | output | 1 | 0: pull-up vs reference, 1: pull-up vs pull-down |
| trial_pu_o | output | PU_W | Trial pull-up code |
| trial_pu_p1_o | output | PU_W | Trial pull-up code plus one, saturated |
| trial_pd_o | output | PD_W | Trial pull-down code |
| trial_pd_p1_o | output | PD_W | Trial pull-down code plus one, saturated |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| cal_pu_o | output | PU_W | Final pull-up code |
| cal_pd_o | output | PD_W | Final pull-down code |

## Verification
The bench builds the block with SETTLE_CYC=4 and IVL_W=12, keeping the default code widths and offset of 3. The short settle window keeps a full three-phase run of up to 79 trials under a few hundred cycles. This puts every sweep boundary within reach: a pull-up sweep that never sees a 1, a pull-down sweep that never sees a 0, and an offset that saturates at 15. The comparator model returns an inverted answer until it has been powered for the full window, so a sample taken early shows up as a wrong code.

// File: rtl/zq_pkg.sv
package zq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_PU_REF = 2'd0,
        PH_PD     = 2'd1,
        PH_PU_PD  = 2'd2
    } seq_phase_t;

endpackage

// File: rtl/zq_code_inc.sv
module zq_code_inc #(
    parameter int W = 5
) (
    input  logic [W-1:0] code_i,
    output logic [W-1:0] code_p1_o
);
    localparam logic [W-1:0] TOP = '1;

    always_comb begin
        code_p1_o = (code_i == TOP) ? TOP : code_i + 1'b1;
    end
endmodule

// File: rtl/zq_settle_timer.sv
module zq_settle_timer #(
    parameter int SETTLE_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic last_o
);
    localparam int CNT_W = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        last_o = run_i && (cnt_q == LAST);
        if (!run_i || last_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R5: the counter never runs past the end of the window
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/zq_recal_timer.sv
module zq_recal_timer #(
    parameter int IVL_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             idle_i,
    input  logic [IVL_W-1:0] interval_i,
    output logic             fire_o
);
    logic [IVL_W-1:0] cnt_d, cnt_q;

    always_comb begin
        fire_o = en_i && idle_i && (interval_i != '0)
                 && (cnt_q >= interval_i - 1'b1);
        if (!en_i || !idle_i || fire_o) cnt_d = '0;
        else                            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9: a zero interval never fires
    a_r9_zero_ivl: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_i == '0) |-> !fire_o);
endmodule

// File: rtl/zq_search_seq.sv
module zq_search_seq
    import zq_pkg::*;
#(
    parameter int PU_W       = 5,
    parameter int PD_W       = 4,
    parameter int SETTLE_CYC = 30,
    parameter int PD_OFFSET  = 3,
    parameter int IVL_W      = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             lp_mode_i,
    input  logic             recal_en_i,
    input  logic [IVL_W-1:0] recal_interval_i,
    input  logic             cmp_result_i,
    output logic             cmp_en_o,
    output logic             cmp_sel_o,
    output logic [PU_W-1:0]  trial_pu_o,
    output logic [PU_W-1:0]  trial_pu_p1_o,
    output logic [PD_W-1:0]  trial_pd_o,
    output logic [PD_W-1:0]  trial_pd_p1_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [PU_W-1:0]  cal_pu_o,
    output logic [PD_W-1:0]  cal_pd_o
);
    localparam logic [PU_W-1:0] PU_MAX  = '1;
    localparam logic [PD_W-1:0] PD_MAX  = '1;
    localparam logic [PD_W-1:0] PD_LAST = PD_MAX - 1'b1;
    localparam logic [PD_W:0]   PD_OFS  = (PD_W+1)'(PD_OFFSET);

    typedef struct packed {
        seq_state_t      state;
        seq_phase_t      phase;
        logic            lp;
        logic            sel;
        logic            done;
        logic [PU_W-1:0] tr_pu;
        logic [PD_W-1:0] tr_pd;
        logic [PU_W-1:0] cal_pu;
        logic [PD_W-1:0] cal_pd;
    } seq_t;

    seq_t d, q;

    logic            sample;
    logic            recal_fire;
    logic            go;
    logic            pd_hit;
    logic [PD_W-1:0] pd_res;
    logic [PD_W:0]   pd_sum;
    logic [PD_W-1:0] pd_ofs;

    zq_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (cmp_en_o),
        .last_o (sample)
    );

    zq_recal_timer #(.IVL_W(IVL_W)) u_recal (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (recal_en_i),
        .idle_i     (!busy_o),
        .interval_i (recal_interval_i),
        .fire_o     (recal_fire)
    );

    zq_code_inc #(.W(PU_W)) u_pu_inc (.code_i(q.tr_pu), .code_p1_o(trial_pu_p1_o));
    zq_code_inc #(.W(PD_W)) u_pd_inc (.code_i(q.tr_pd), .code_p1_o(trial_pd_p1_o));

    assign go = start_i || recal_fire;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        pd_hit = !cmp_result_i && (q.tr_pd != '0);
        pd_res = pd_hit ? q.tr_pd - 1'b1 : '0;
        pd_sum = {1'b0, pd_res} + PD_OFS;
        pd_ofs = (pd_sum > {1'b0, PD_MAX}) ? PD_MAX : pd_sum[PD_W-1:0];

        case (q.state)
            ST_IDLE: begin
                if (go) begin
                    d.state = ST_RUN;
                    d.phase = PH_PU_REF;
                    d.lp    = lp_mode_i;
                    d.sel   = 1'b0;
                    d.tr_pu = '0;
                    d.tr_pd = '0;
                end
            end
            ST_GAP: d.state = ST_RUN;
            ST_RUN: begin
                if (sample) begin
                    d.state = ST_GAP;
                    case (q.phase)
                        PH_PU_REF: begin
                            if (cmp_result_i || q.tr_pu == PU_MAX) begin
                                d.tr_pu = cmp_result_i ? q.tr_pu : '0;
                                d.tr_pd = '0;
                                d.sel   = 1'b1;
                                d.phase = PH_PD;
                            end else begin
                                d.tr_pu = q.tr_pu + 1'b1;
                            end
                        end
                        PH_PD: begin
                            if (pd_hit || q.tr_pd == PD_LAST) begin
                                if (q.lp) begin
                                    d.phase = PH_PU_PD;
                                    d.tr_pd = pd_ofs;
                                    d.tr_pu = '0;
                                end else begin
                                    d.state  = ST_IDLE;
                                    d.done   = 1'b1;
                                    d.cal_pu = q.tr_pu;
                                    d.cal_pd = pd_res;
                                end
                            end else begin
                                d.tr_pd = q.tr_pd + 1'b1;
                            end
                        end
                        default: begin
                            if (cmp_result_i || q.tr_pu == PU_MAX) begin
                                d.state  = ST_IDLE;
                                d.done   = 1'b1;
                                d.cal_pu = cmp_result_i ? q.tr_pu : '0;
                                d.cal_pd = q.tr_pd;
                            end else begin
                                d.tr_pu = q.tr_pu + 1'b1;
                            end
                        end
                    endcase
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, phase: PH_PU_REF, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cmp_en_o   = (q.state == ST_RUN);
    assign cmp_sel_o  = q.sel;
    assign trial_pu_o = q.tr_pu;
    assign trial_pd_o = q.tr_pd;
    assign busy_o     = (q.state != ST_IDLE);
    assign done_o     = q.done;
    assign cal_pu_o   = q.cal_pu;
    assign cal_pd_o   = q.cal_pd;

    // R5: sampling happens only after the comparator has been on for a cycle
    a_r5_sample_settled: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (cmp_en_o && $past(cmp_en_o)));
    // R5: comparator is switched off right after each sample
    a_r5_off_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> !cmp_en_o);
    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7: results only move together with done
    a_r7_cal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(cal_pu_o) && $stable(cal_pd_o)));
    // R8: trial codes move only on a sample while a run is in progress
    a_r8_busy_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !sample) |=> ($stable(trial_pu_o) && $stable(trial_pd_o)));
    // R9: a timer request launches a run
    a_r9_fire_starts: assert property (@(posedge clk) disable iff (!rst_n)
        recal_fire |=> busy_o);
    // R4: plus-one outputs never fall below the trial codes
    a_r4_p1_order: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_pu_p1_o >= trial_pu_o) && (trial_pd_p1_o >= trial_pd_o));
    // R2: reference comparisons hold the pull-down code at zero
    a_r2_ref_pd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en_o && !cmp_sel_o) |-> (trial_pd_o == '0));
    // R3: the pull-down sweep stops at its last allowed code
    a_r3_pd_range: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en_o && q.phase == PH_PD) |-> (trial_pd_o <= PD_LAST));
endmodule

// File: tb/zq_search_seq_tb.sv
module zq_search_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int IVL_W      = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             lp_mode_i = 1'b0;
    logic             recal_en_i = 1'b0;
    logic [IVL_W-1:0] recal_interval_i = '0;
    logic             cmp_result_i;
    logic             cmp_en_o, cmp_sel_o, busy_o, done_o;
    logic [4:0]       trial_pu_o, trial_pu_p1_o, cal_pu_o;
    logic [3:0]       trial_pd_o, trial_pd_p1_o, cal_pd_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int thr = 0;
    int off = 0;
    int en_cnt = 0;
    int n_trials = 0;
    int run_len = 0;
    int p1_err = 0;
    int len_err = 0;
    int sel_err = 0;
    bit en_prev = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zq_search_seq #(
        .PU_W(5), .PD_W(4), .SETTLE_CYC(SETTLE), .PD_OFFSET(3), .IVL_W(IVL_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .lp_mode_i(lp_mode_i),
        .recal_en_i(recal_en_i), .recal_interval_i(recal_interval_i),
        .cmp_result_i(cmp_result_i), .cmp_en_o(cmp_en_o), .cmp_sel_o(cmp_sel_o),
        .trial_pu_o(trial_pu_o), .trial_pu_p1_o(trial_pu_p1_o),
        .trial_pd_o(trial_pd_o), .trial_pd_p1_o(trial_pd_p1_o),
        .busy_o(busy_o), .done_o(done_o), .cal_pu_o(cal_pu_o), .cal_pd_o(cal_pd_o)
    );

    function automatic bit ideal(input int pu, input int pd, input bit sel);
        if (!sel) return pu >= thr;
        return (pu - 2*pd) >= off;
    endfunction

    // comparator model: answer is inverted until powered a full window
    always @(posedge clk) en_cnt <= cmp_en_o ? en_cnt + 1 : 0;
    always_comb begin
        cmp_result_i = ideal(int'(trial_pu_o), int'(trial_pd_o), cmp_sel_o);
        if (!(cmp_en_o && en_cnt >= SETTLE-1)) cmp_result_i = ~cmp_result_i;
    end

    // per-cycle monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmp_en_o) begin
                if (!en_prev) n_trials++;
                run_len++;
                if (int'(trial_pu_p1_o) != ((trial_pu_o == 5'd31) ? 31 : int'(trial_pu_o) + 1)) p1_err++;
                if (int'(trial_pd_p1_o) != ((trial_pd_o == 4'd15) ? 15 : int'(trial_pd_o) + 1)) p1_err++;
                if (!cmp_sel_o && trial_pd_o != 4'd0) sel_err++;
            end else if (en_prev) begin
                if (run_len != SETTLE) len_err++;
                run_len = 0;
            end
            en_prev = cmp_en_o;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic golden(input bit lp, output int epu, output int epd, output int ntr);
        ntr = 0; epu = 0; epd = 0;
        for (int i = 0; i < 32; i++) begin
            ntr++;
            if (ideal(i, 0, 1'b0)) begin epu = i; break; end
        end
        for (int i = 0; i < 15; i++) begin
            ntr++;
            if (!ideal(epu, i, 1'b1) && i > 0) begin epd = i - 1; break; end
        end
        if (lp) begin
            epd = (epd + 3 > 15) ? 15 : epd + 3;
            epu = 0;
            for (int i = 0; i < 32; i++) begin
                ntr++;
                if (ideal(i, epd, 1'b1)) begin epu = i; break; end
            end
        end
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (!done_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // one full run; extra_starts pulses start while busy
    task automatic run_cal(input string req, input int t, input int o, input bit lp,
                           input bit extra_starts);
        int epu, epd, ntr, cyc;
        thr = t; off = o;
        golden(lp, epu, epd, ntr);
        n_trials = 0; p1_err = 0; len_err = 0; sel_err = 0;
        @(negedge clk);
        lp_mode_i = lp;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lp_mode_i = 1'b0;
        chk("R10", "busy after start", int'(busy_o), 1);
        if (extra_starts) begin
            repeat (7) @(negedge clk);
            start_i = 1'b1;
            lp_mode_i = ~lp;
            repeat (3) @(negedge clk);
            start_i = 1'b0;
            lp_mode_i = 1'b0;
        end
        wait_done(cyc);
        chk(req, "done seen", int'(done_o), 1);
        chk(req, "pull-up result", int'(cal_pu_o), epu);
        chk(req, "pull-down result", int'(cal_pd_o), epd);
        chk(lp ? "R6" : "R3", "trial count", n_trials, ntr);
        chk("R10", "busy low at done", int'(busy_o), 0);
        chk("R4", "plus-one errors", p1_err, 0);
        chk("R5", "window length errors", len_err, 0);
        chk("R2", "ref compare select/pd errors", sel_err, 0);
        @(negedge clk);
        chk("R7", "done width", int'(done_o), 0);
    endtask

    task automatic t_reset();
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "done", int'(done_o), 0);
        chk("R1", "cmp_en", int'(cmp_en_o), 0);
        chk("R1", "cal_pu", int'(cal_pu_o), 0);
        chk("R1", "cal_pd", int'(cal_pd_o), 0);
    endtask

    task automatic t_ignore_busy_start();
        int busy_seen = 0;
        run_cal("R8", 9, -6, 1'b0, 1'b1);
        repeat (30) begin
            @(negedge clk);
            if (busy_o) busy_seen++;
        end
        chk("R8", "no extra run after ignored start", busy_seen, 0);
        chk("R7", "pull-up held", int'(cal_pu_o), 9);
        chk("R7", "pull-down held", int'(cal_pd_o), 7);
    endtask

    task automatic t_recal();
        int cyc, n;
        recal_interval_i = 12'd40;
        recal_en_i = 1'b1;
        thr = 3; off = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(cyc);
        n = 0;
        while (!busy_o && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk("R9", "cycles from done to automatic run", n, 40);
        recal_en_i = 1'b0;
        @(negedge clk);
        wait_done(cyc);
        chk("R9", "automatic run pull-up", int'(cal_pu_o), 3);
        recal_interval_i = '0;
        recal_en_i = 1'b1;
        n = 0;
        repeat (200) begin
            @(negedge clk);
            if (busy_o) n++;
        end
        chk("R9", "zero interval launches nothing", n, 0);
        recal_en_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_cal("R3", 9, -6, 1'b0, 1'b0);    // normal: pu 9, pd 7
        run_cal("R2", 40, 1, 1'b0, 1'b0);    // no 1 in pull-up sweep, no pd hit past 0
        run_cal("R3", 20, -20, 1'b0, 1'b0);  // pull-down never returns 0
        run_cal("R6", 31, 4, 1'b1, 1'b0);    // pd 13 + 3 saturates at 15, re-search misses
        run_cal("R6", 5, -3, 1'b1, 1'b0);    // pd 4 + 3 = 7, re-search gives 11
        t_ignore_busy_start();
        t_recal();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule